// File: doc/BRIEF.md
# Endpoint Packet Length Counter with Automatic Buffer Validation

This block keeps the packet byte count for each endpoint of a USB device controller whose endpoint buffers a microcontroller fills and drains through a programmed-I/O data port. For every endpoint it holds a maximum packet size, a current packet length and a byte counter. Writing the maximum packet size also sets the current length. The microcontroller may then shorten the length for one packet. Each data port write on a transmit (IN) endpoint advances the counter by the bytes it carries. When the counter reaches the length, the block emits a one-cycle validate pulse, clears the counter and restores the length to the maximum packet size.

On a receive (OUT) endpoint, every acknowledged packet loads both the length and a remaining-byte count with the number of bytes the host sent. Each data port read hands back one or two bytes from the buffer and reduces the remaining count. An empty flag shows when nothing is left. The port runs in a 16-bit or an 8-bit mode. In 16-bit mode an odd final byte always travels on the low byte lane.

The FIFO memory is outside the block and must take or supply a word on every strobe, with no back-pressure. Register select codes on `mcu_sel` are 0 for the data port, 1 for the current length and 2 for the maximum packet size; code 3 reads as zero. Endpoint direction is fixed by the `IN_MASK` parameter (bit set means IN). Register reads return data on `mcu_rdata` in the cycle after the read strobe.

Top module: `ep_len_ctrl`

## Requirements
- R1: A write to select code 2 stores the maximum packet size and, from the next cycle, the current length of that endpoint reads back the same value.
- R2: A write to select code 1 replaces the current length when the value is not above the maximum packet size; a larger value is ignored and the length keeps its old value.
- R3: A USB bus reset clears the current length and the byte counter of every endpoint to zero.
- R4: On an IN endpoint, the write that brings the written-byte count to the current length produces `val_pulse` high for exactly the next cycle, with `val_ep` and `val_len` giving the endpoint and the packet length; no earlier write of that packet pulses.
- R5: After a validation the counter is zero and the current length reads back as the maximum packet size.
- R6: In 16-bit mode a data write counts 2 bytes with `fifo_wr_be` = 2'b11, except when one byte remains, which counts 1 byte with `fifo_wr_be` = 2'b01 and the data on bits 7:0.
- R7: In 8-bit mode a data write counts 1 byte, presents `fifo_wr_be` = 2'b01 and drives `fifo_wr_data[15:8]` as zero whatever the upper byte of `mcu_wdata` holds.
- R8: `rx_ack` on an OUT endpoint loads its current length and remaining count with `rx_count`; `rx_ack` naming an IN endpoint changes nothing.
- R9: A data read on an OUT endpoint with bytes remaining returns `fifo_rd_data` unchanged and takes 2 bytes in 16-bit mode when at least 2 remain; otherwise it takes 1 byte and returns only bits 7:0 with the upper byte zero.
- R10: `out_empty` is high when the indexed OUT endpoint has no bytes remaining; a data read then returns zero and raises no `fifo_rd_req`.
- R11: A data write to an IN endpoint whose current length is zero raises no `fifo_wr_valid` and no validation.
- R12: Priority in one cycle is bus reset, then `rx_ack`, then the microcontroller access: a data read on the endpoint being acknowledged is dropped and returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_bus_reset | input | 1 | USB bus reset seen by the device |
| mcu_idx | input | IDX_W | Endpoint index for register accesses |
| mcu_sel | input | 2 | Register select: 0 data, 1 length, 2 max packet size |
| mcu_wr | input | 1 | Register write strobe |
| mcu_rd | input | 1 | Register read strobe |
| mcu_bus16 | input | 1 | 1 = 16-bit data port, 0 = 8-bit |
| mcu_wdata | input | 16 | Write data |
| mcu_rdata | output | 16 | Read data, valid the cycle after `mcu_rd` |
| out_empty | output | 1 | Indexed OUT endpoint has no bytes left |
| rx_ack | input | 1 | Packet received and acknowledged |
| rx_ep | input | IDX_W | Endpoint of the acknowledged packet |
| rx_count | input | LEN_W | Bytes in the acknowledged packet |
| fifo_wr_valid | output | 1 | Write strobe toward the endpoint buffer |
| fifo_wr_be | output | 2 | Byte lanes carried by the write |
| fifo_wr_data | output | 16 | Write data toward the buffer |
| fifo_rd_req | output | 1 | Read strobe toward the endpoint buffer |
| fifo_rd_be | output | 2 | Byte lanes taken by the read |
| fifo_rd_data | input | 16 | Data from the buffer, same cycle as `fifo_rd_req` |
| val_pulse | output | 1 | One-cycle buffer validate |
| val_ep | output | IDX_W | Endpoint validated |
| val_len | output | LEN_W | Length of the validated packet |

## Verification
The transmit counter is driven by a table of packets that differ in maximum size, length override and port width: full packets, an even short packet, an odd short packet whose last write must fall back to one byte, an 8-bit packet and single-byte packets. Together these separate a counter that always adds two from one that honours the last-byte rule, and a pulse raised one write early or late from a correct one. Receive endpoints are drained in both widths from odd and even counts, then read past empty. Bus reset is raised alone and together with an acknowledge to show the priority order.

// File: rtl/ep_len_pkg.sv
package ep_len_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_MPS  = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;

  localparam int PORT_W = 16;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/ep_len_slot.sv
// State of one endpoint: max packet size, current length, byte counter.
module ep_len_slot #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst,
  input  logic             rx_ld,
  input  logic [LEN_W-1:0] rx_val,
  input  logic             mps_ld,
  input  logic             len_ld,
  input  logic [LEN_W-1:0] wval,
  input  logic             wr_en,
  input  logic [1:0]       inc,
  input  logic             rd_en,
  input  logic [1:0]       dec,
  output logic [LEN_W-1:0] mps_q,
  output logic [LEN_W-1:0] blen_q,
  output logic [LEN_W-1:0] cnt_q,
  output logic             fire
);
  logic [LEN_W:0] cnt_next;

  assign cnt_next = {1'b0, cnt_q} + {{(LEN_W-1){1'b0}}, inc};
  assign fire     = wr_en && !bus_rst && (blen_q != '0) &&
                    (cnt_next >= {1'b0, blen_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mps_q  <= '0;
      blen_q <= '0;
      cnt_q  <= '0;
    end else if (bus_rst) begin
      blen_q <= '0;
      cnt_q  <= '0;
    end else if (rx_ld) begin
      blen_q <= rx_val;
      cnt_q  <= rx_val;
    end else if (mps_ld) begin
      mps_q  <= wval;
      blen_q <= wval;
      cnt_q  <= '0;
    end else if (len_ld) begin
      if (wval <= mps_q) blen_q <= wval;
    end else if (wr_en) begin
      if (fire) begin
        cnt_q  <= '0;
        blen_q <= mps_q;
      end else begin
        cnt_q <= cnt_next[LEN_W-1:0];
      end
    end else if (rd_en) begin
      cnt_q <= cnt_q - {{(LEN_W-2){1'b0}}, dec};
    end
  end
endmodule

// File: rtl/ep_len_lane.sv
// Byte-lane steering and count step for the data port.
module ep_len_lane #(
  parameter int LEN_W = 16
) (
  input  logic                           bus16,
  input  logic [LEN_W-1:0]               blen,
  input  logic [LEN_W-1:0]               cnt,
  input  logic [ep_len_pkg::PORT_W-1:0]  wdata,
  input  logic [ep_len_pkg::PORT_W-1:0]  fifo_rdata,
  output logic [1:0]                     inc,
  output logic [1:0]                     wr_be,
  output logic [ep_len_pkg::PORT_W-1:0]  wr_data,
  output logic [1:0]                     dec,
  output logic [1:0]                     rd_be,
  output logic [ep_len_pkg::PORT_W-1:0]  rd_data
);
  import ep_len_pkg::*;
  localparam int HI_W = PORT_W - BYTE_W;

  logic one_left_wr;
  logic two_left_rd;
  logic wide_wr;
  logic wide_rd;

  assign one_left_wr = ({1'b0, cnt} + 1'b1) >= {1'b0, blen};
  assign two_left_rd = cnt >= LEN_W'(2);
  assign wide_wr     = bus16 && !one_left_wr;
  assign wide_rd     = bus16 && two_left_rd;

  always_comb begin
    inc     = wide_wr ? 2'd2 : 2'd1;
    wr_be   = wide_wr ? 2'b11 : 2'b01;
    wr_data = wide_wr ? wdata : {{HI_W{1'b0}}, wdata[BYTE_W-1:0]};
    dec     = wide_rd ? 2'd2 : 2'd1;
    rd_be   = wide_rd ? 2'b11 : 2'b01;
    rd_data = wide_rd ? fifo_rdata : {{HI_W{1'b0}}, fifo_rdata[BYTE_W-1:0]};
  end
endmodule

// File: rtl/ep_len_ctrl.sv
module ep_len_ctrl #(
  parameter int              NUM_EP  = 4,
  parameter int              LEN_W   = 16,
  parameter logic [NUM_EP-1:0] IN_MASK = 4'b0101,
  localparam int             IDX_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usb_bus_reset,
  input  logic [IDX_W-1:0] mcu_idx,
  input  logic [1:0]       mcu_sel,
  input  logic             mcu_wr,
  input  logic             mcu_rd,
  input  logic             mcu_bus16,
  input  logic [15:0]      mcu_wdata,
  output logic [15:0]      mcu_rdata,
  output logic             out_empty,
  input  logic             rx_ack,
  input  logic [IDX_W-1:0] rx_ep,
  input  logic [LEN_W-1:0] rx_count,
  output logic             fifo_wr_valid,
  output logic [1:0]       fifo_wr_be,
  output logic [15:0]      fifo_wr_data,
  output logic             fifo_rd_req,
  output logic [1:0]       fifo_rd_be,
  input  logic [15:0]      fifo_rd_data,
  output logic             val_pulse,
  output logic [IDX_W-1:0] val_ep,
  output logic [LEN_W-1:0] val_len
);
  import ep_len_pkg::*;

  logic [NUM_EP-1:0][LEN_W-1:0] mps_all;
  logic [NUM_EP-1:0][LEN_W-1:0] blen_all;
  logic [NUM_EP-1:0][LEN_W-1:0] cnt_all;
  logic [NUM_EP-1:0]            fire_all;

  logic             idx_ok;
  logic             sel_in;
  logic [LEN_W-1:0] mps_sel;
  logic [LEN_W-1:0] blen_sel;
  logic [LEN_W-1:0] cnt_sel;
  logic             ack_hit;
  logic             mcu_live;
  logic             data_wr;
  logic             data_rd;
  logic [1:0]       inc;
  logic [1:0]       dec;
  logic [1:0]       wr_be;
  logic [1:0]       rd_be;
  logic [15:0]      wr_data;
  logic [15:0]      rd_data;
  logic [LEN_W-1:0] wval;

  assign idx_ok   = (32'(mcu_idx) < NUM_EP);
  assign sel_in   = idx_ok && IN_MASK[mcu_idx];
  assign mps_sel  = idx_ok ? mps_all[mcu_idx]  : '0;
  assign blen_sel = idx_ok ? blen_all[mcu_idx] : '0;
  assign cnt_sel  = idx_ok ? cnt_all[mcu_idx]  : '0;
  assign ack_hit  = rx_ack && (rx_ep == mcu_idx) && !IN_MASK[rx_ep];
  assign mcu_live = idx_ok && !usb_bus_reset && !ack_hit;
  assign wval     = mcu_wdata[LEN_W-1:0];

  assign data_wr = mcu_live && mcu_wr && (mcu_sel == SEL_DATA) &&
                   sel_in && (blen_sel != '0);
  assign data_rd = mcu_live && mcu_rd && (mcu_sel == SEL_DATA) &&
                   !sel_in && (cnt_sel != '0);

  ep_len_lane #(.LEN_W(LEN_W)) u_lane (
    .bus16      (mcu_bus16),
    .blen       (blen_sel),
    .cnt        (cnt_sel),
    .wdata      (mcu_wdata),
    .fifo_rdata (fifo_rd_data),
    .inc        (inc),
    .wr_be      (wr_be),
    .wr_data    (wr_data),
    .dec        (dec),
    .rd_be      (rd_be),
    .rd_data    (rd_data)
  );

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic here;
    logic rx_ld;
    assign here  = (32'(mcu_idx) == e);
    assign rx_ld = rx_ack && (32'(rx_ep) == e) && !IN_MASK[e];

    ep_len_slot #(.LEN_W(LEN_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_rst (usb_bus_reset),
      .rx_ld   (rx_ld),
      .rx_val  (rx_count),
      .mps_ld  (here && mcu_live && mcu_wr && (mcu_sel == SEL_MPS)),
      .len_ld  (here && mcu_live && mcu_wr && (mcu_sel == SEL_LEN)),
      .wval    (wval),
      .wr_en   (here && data_wr),
      .inc     (inc),
      .rd_en   (here && data_rd),
      .dec     (dec),
      .mps_q   (mps_all[e]),
      .blen_q  (blen_all[e]),
      .cnt_q   (cnt_all[e]),
      .fire    (fire_all[e])
    );
  end

  assign fifo_wr_valid = data_wr;
  assign fifo_wr_be    = data_wr ? wr_be : 2'b00;
  assign fifo_wr_data  = data_wr ? wr_data : 16'h0000;
  assign fifo_rd_req   = data_rd;
  assign fifo_rd_be    = data_rd ? rd_be : 2'b00;
  assign out_empty     = idx_ok && !sel_in && (cnt_sel == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcu_rdata <= '0;
    end else if (mcu_rd) begin
      unique case (reg_sel_e'(mcu_sel))
        SEL_DATA: mcu_rdata <= data_rd ? rd_data : 16'h0000;
        SEL_LEN:  mcu_rdata <= 16'(blen_sel);
        SEL_MPS:  mcu_rdata <= 16'(mps_sel);
        default:  mcu_rdata <= 16'h0000;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_pulse <= 1'b0;
      val_ep    <= '0;
      val_len   <= '0;
    end else begin
      val_pulse <= |fire_all;
      if (|fire_all) begin
        val_ep  <= mcu_idx;
        val_len <= blen_sel;
      end
    end
  end
endmodule

// File: rtl/ep_len_chk.sv
module ep_len_chk #(
  parameter int NUM_EP = 4,
  parameter int LEN_W  = 16,
  localparam int IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         usb_bus_reset,
  input logic [IDX_W-1:0]             mcu_idx,
  input logic [1:0]                   mcu_sel,
  input logic                         mcu_wr,
  input logic                         mcu_rd,
  input logic                         mcu_bus16,
  input logic [15:0]                  mcu_wdata,
  input logic [15:0]                  mcu_rdata,
  input logic                         out_empty,
  input logic                         rx_ack,
  input logic [IDX_W-1:0]             rx_ep,
  input logic                         fifo_wr_valid,
  input logic [1:0]                   fifo_wr_be,
  input logic [15:0]                  fifo_wr_data,
  input logic                         fifo_rd_req,
  input logic [1:0]                   fifo_rd_be,
  input logic                         val_pulse,
  input logic [LEN_W-1:0]             val_len,
  input logic [NUM_EP-1:0][LEN_W-1:0] blen_all
);
  assert_mps_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_wr && mcu_sel == 2'd2 && !usb_bus_reset && !rx_ack &&
     32'(mcu_idx) < NUM_EP)
    |=> blen_all[$past(mcu_idx)] == $past(mcu_wdata[LEN_W-1:0]));

  assert_bus_reset_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    usb_bus_reset |=> blen_all == '0);

  assert_val_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    val_pulse |-> val_len != '0);

  assert_low_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_valid |-> (fifo_wr_be == 2'b11 || fifo_wr_be == 2'b01));

  assert_narrow_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_valid && !mcu_bus16) |-> (fifo_wr_data[15:8] == 8'h00 && fifo_wr_be == 2'b01));

  assert_read_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd_req && !mcu_bus16) |-> fifo_rd_be == 2'b01);

  assert_empty_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_rd && mcu_sel == 2'd0 && out_empty) |=> mcu_rdata == 16'h0000);

  assert_zero_len_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_wr && mcu_sel == 2'd0 && 32'(mcu_idx) < NUM_EP && blen_all[mcu_idx] == '0)
    |-> !fifo_wr_valid);
endmodule

bind ep_len_ctrl ep_len_chk #(.NUM_EP(NUM_EP), .LEN_W(LEN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .usb_bus_reset (usb_bus_reset),
  .mcu_idx       (mcu_idx),
  .mcu_sel       (mcu_sel),
  .mcu_wr        (mcu_wr),
  .mcu_rd        (mcu_rd),
  .mcu_bus16     (mcu_bus16),
  .mcu_wdata     (mcu_wdata),
  .mcu_rdata     (mcu_rdata),
  .out_empty     (out_empty),
  .rx_ack        (rx_ack),
  .rx_ep         (rx_ep),
  .fifo_wr_valid (fifo_wr_valid),
  .fifo_wr_be    (fifo_wr_be),
  .fifo_wr_data  (fifo_wr_data),
  .fifo_rd_req   (fifo_rd_req),
  .fifo_rd_be    (fifo_rd_be),
  .val_pulse     (val_pulse),
  .val_len       (val_len),
  .blen_all      (blen_all)
);

// File: tb/sim_ep_len_ctrl.sv
`timescale 1ns/100ps
module sim_ep_len_ctrl;
  localparam int NUM_EP = 4;
  localparam int LEN_W  = 16;
  localparam int IDX_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic usb_bus_reset = 1'b0;
  logic [IDX_W-1:0] mcu_idx = '0;
  logic [1:0] mcu_sel = 2'd0;
  logic mcu_wr = 1'b0, mcu_rd = 1'b0, mcu_bus16 = 1'b1;
  logic [15:0] mcu_wdata = '0;
  logic [15:0] mcu_rdata;
  logic out_empty;
  logic rx_ack = 1'b0;
  logic [IDX_W-1:0] rx_ep = '0;
  logic [LEN_W-1:0] rx_count = '0;
  logic fifo_wr_valid, fifo_rd_req;
  logic [1:0] fifo_wr_be, fifo_rd_be;
  logic [15:0] fifo_wr_data;
  logic [15:0] fifo_rd_data = 16'hBEEF;
  logic val_pulse;
  logic [IDX_W-1:0] val_ep;
  logic [LEN_W-1:0] val_len;

  int errors = 0;
  int checks = 0;
  logic s_wv, s_rreq;
  logic [1:0] s_be;
  logic [15:0] s_wd;

  always #2 clk = ~clk;

  ep_len_ctrl #(.NUM_EP(NUM_EP), .LEN_W(LEN_W), .IN_MASK(4'b0101)) u0 (.*);

  typedef struct packed {
    logic [15:0] mps;
    logic [15:0] ovr;
    logic        wide;
    logic [15:0] nwr;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{mps:16'd64, ovr:16'd0,  wide:1'b1, nwr:16'd32},
    '{mps:16'd64, ovr:16'd62, wide:1'b1, nwr:16'd31},
    '{mps:16'd64, ovr:16'd61, wide:1'b1, nwr:16'd31},
    '{mps:16'd8,  ovr:16'd0,  wide:1'b0, nwr:16'd8},
    '{mps:16'd5,  ovr:16'd0,  wide:1'b1, nwr:16'd3},
    '{mps:16'd1,  ovr:16'd0,  wide:1'b1, nwr:16'd1}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic rd, input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    mcu_wr = wr; mcu_rd = rd; mcu_sel = sel; mcu_wdata = d;
    #1;
    s_wv = fifo_wr_valid; s_be = fifo_wr_be; s_wd = fifo_wr_data; s_rreq = fifo_rd_req;
    @(posedge clk); #1;
    mcu_wr = 1'b0; mcu_rd = 1'b0;
  endtask

  task automatic rx(input logic [IDX_W-1:0] ep, input logic [15:0] n, input logic brst);
    @(negedge clk);
    rx_ack = 1'b1; rx_ep = ep; rx_count = n; usb_bus_reset = brst;
    @(posedge clk); #1;
    rx_ack = 1'b0; usb_bus_reset = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state (R3)
    access(1'b0, 1'b1, 2'd1, 16'h0);
    chk(mcu_rdata == 16'h0, "R3 reset length", mcu_rdata, 0);
    chk(val_pulse == 1'b0, "R4 reset no pulse", val_pulse, 0);
    mcu_idx = 2'd1; #1;
    chk(out_empty == 1'b1, "R10 reset empty", out_empty, 1);

    // table of IN packets on endpoint 0 (R4 R5 R6 R7)
    mcu_idx = 2'd0;
    foreach (VECS[k]) begin
      logic [15:0] exp_len;
      logic [1:0]  exp_be;
      mcu_bus16 = VECS[k].wide;
      exp_len = (VECS[k].ovr != 0) ? VECS[k].ovr : VECS[k].mps;
      exp_be  = (VECS[k].wide && !exp_len[0]) ? 2'b11 : 2'b01;
      access(1'b1, 1'b0, 2'd2, VECS[k].mps);
      if (VECS[k].ovr != 0) access(1'b1, 1'b0, 2'd1, VECS[k].ovr);
      for (int i = 1; i <= int'(VECS[k].nwr); i++) begin
        access(1'b1, 1'b0, 2'd0, 16'hA500 + 16'(i));
        if (i < int'(VECS[k].nwr)) begin
          chk(val_pulse == 1'b0, "R4 early pulse", val_pulse, 0);
          chk(s_be == (VECS[k].wide ? 2'b11 : 2'b01), "R6 R7 lane width", s_be,
              VECS[k].wide ? 2'b11 : 2'b01);
        end else begin
          chk(val_pulse == 1'b1, "R4 pulse on last write", val_pulse, 1);
          chk(val_len == exp_len && val_ep == 2'd0, "R4 packet length", val_len, exp_len);
          chk(s_be == exp_be, "R6 final lane", s_be, exp_be);
        end
      end
      access(1'b0, 1'b1, 2'd1, 16'h0);
      chk(val_pulse == 1'b0, "R4 single cycle pulse", val_pulse, 0);
      chk(mcu_rdata == VECS[k].mps, "R5 length reverts", mcu_rdata, VECS[k].mps);
    end

    // R7 upper byte ignored in 8-bit mode
    mcu_bus16 = 1'b0;
    access(1'b1, 1'b0, 2'd2, 16'd4);
    access(1'b1, 1'b0, 2'd0, 16'h12AB);
    chk(s_wd == 16'h00AB && s_be == 2'b01, "R7 narrow write", s_wd, 16'h00AB);
    mcu_bus16 = 1'b1;

    // R2 override limits, R1 reload on endpoint 2
    mcu_idx = 2'd2;
    access(1'b1, 1'b0, 2'd2, 16'd16);
    access(1'b1, 1'b0, 2'd1, 16'd20);
    access(1'b0, 1'b1, 2'd1, 16'h0);
    chk(mcu_rdata == 16'd16, "R2 larger ignored", mcu_rdata, 16);
    access(1'b1, 1'b0, 2'd1, 16'd10);
    access(1'b0, 1'b1, 2'd1, 16'h0);
    chk(mcu_rdata == 16'd10, "R2 smaller accepted", mcu_rdata, 10);
    access(1'b1, 1'b0, 2'd2, 16'd40);
    access(1'b0, 1'b1, 2'd1, 16'h0);
    chk(mcu_rdata == 16'd40, "R1 mps reloads length", mcu_rdata, 40);

    // R3 bus reset, R11 zero length drop
    mcu_idx = 2'd0;
    access(1'b1, 1'b0, 2'd2, 16'd32);
    @(negedge clk); usb_bus_reset = 1'b1; @(posedge clk); #1 usb_bus_reset = 1'b0;
    access(1'b0, 1'b1, 2'd1, 16'h0);
    chk(mcu_rdata == 16'd0, "R3 length cleared", mcu_rdata, 0);
    mcu_idx = 2'd2;
    access(1'b0, 1'b1, 2'd1, 16'h0);
    chk(mcu_rdata == 16'd0, "R3 other endpoint cleared", mcu_rdata, 0);
    mcu_idx = 2'd0;
    access(1'b1, 1'b0, 2'd0, 16'h5555);
    chk(s_wv == 1'b0, "R11 write dropped", s_wv, 0);
    chk(val_pulse == 1'b0, "R11 no validation", val_pulse, 0);

    // R8 ack on IN endpoint ignored
    access(1'b1, 1'b0, 2'd2, 16'd12);
    rx(2'd0, 16'd3, 1'b0);
    access(1'b0, 1'b1, 2'd1, 16'h0);
    chk(mcu_rdata == 16'd12, "R8 IN ack ignored", mcu_rdata, 12);

    // R8 R9 R10 OUT endpoint 1, 16-bit
    mcu_idx = 2'd1;
    rx(2'd1, 16'd5, 1'b0);
    chk(out_empty == 1'b0, "R8 count loaded", out_empty, 0);
    access(1'b0, 1'b1, 2'd1, 16'h0);
    chk(mcu_rdata == 16'd5, "R8 length loaded", mcu_rdata, 5);
    access(1'b0, 1'b1, 2'd0, 16'h0);
    chk(mcu_rdata == 16'hBEEF && s_rreq, "R9 word read 1", mcu_rdata, 16'hBEEF);
    access(1'b0, 1'b1, 2'd0, 16'h0);
    chk(mcu_rdata == 16'hBEEF, "R9 word read 2", mcu_rdata, 16'hBEEF);
    access(1'b0, 1'b1, 2'd0, 16'h0);
    chk(mcu_rdata == 16'h00EF, "R9 odd last byte low lane", mcu_rdata, 16'h00EF);
    chk(out_empty == 1'b1, "R10 empty after drain", out_empty, 1);
    access(1'b0, 1'b1, 2'd0, 16'h0);
    chk(mcu_rdata == 16'h0 && !s_rreq, "R10 read past empty", mcu_rdata, 0);

    // 8-bit OUT drain
    mcu_bus16 = 1'b0;
    rx(2'd1, 16'd2, 1'b0);
    access(1'b0, 1'b1, 2'd0, 16'h0);
    chk(mcu_rdata == 16'h00EF, "R9 narrow read 1", mcu_rdata, 16'h00EF);
    access(1'b0, 1'b1, 2'd0, 16'h0);
    chk(mcu_rdata == 16'h00EF && out_empty, "R9 narrow read 2", mcu_rdata, 16'h00EF);
    mcu_bus16 = 1'b1;

    // R12 priorities
    rx(2'd1, 16'd7, 1'b1);
    access(1'b0, 1'b1, 2'd1, 16'h0);
    chk(mcu_rdata == 16'd0, "R12 reset beats ack", mcu_rdata, 0);
    rx(2'd1, 16'd6, 1'b0);
    @(negedge clk);
    rx_ack = 1'b1; rx_ep = 2'd1; rx_count = 16'd3;
    mcu_rd = 1'b1; mcu_sel = 2'd0;
    #1 s_rreq = fifo_rd_req;
    @(posedge clk); #1;
    rx_ack = 1'b0; mcu_rd = 1'b0;
    chk(mcu_rdata == 16'h0 && !s_rreq, "R12 read dropped on ack", mcu_rdata, 0);
    access(1'b0, 1'b1, 2'd1, 16'h0);
    chk(mcu_rdata == 16'd3, "R12 ack wins", mcu_rdata, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule